// File: doc/BRIEF.md
# Twin-Predicated Element-Width Move Sequencer

This block carries out one vector move between a packed source region and a packed destination region of a 64-bit register file. Each side has its own element width and its own predicate, so a single scalar move can be used in four ways. With a narrow source and a wide destination it unpacks. With a wide source and a narrow destination it packs. A sparse source predicate compresses the vector. A sparse destination predicate expands it.

After a start pulse the sequencer walks a source index and a destination index separately. It reads the source register that holds the current source element, resizes that element to the destination width, and writes it with byte enables into the register that holds the current destination slot. The source read port is combinational: the read address goes out and the data comes back in the same cycle. Each cycle carries out exactly one step. A done pulse marks the end of the operation.

Top module: `twpred_move`

## Requirements
- R1: Width code 0 selects 64-bit elements, code 1 selects 8-bit, code 2 selects 16-bit and code 3 selects 32-bit. The source and the destination each take their own code.
- R2: Element k of a side sits at byte offset k×(element bytes) from that side's base register. Elements are packed from the least significant byte of each 64-bit register upward. `wr_be` covers exactly the bytes of the written element, and `wr_data` is zero outside those bytes.
- R3: A source element is zero-extended when the destination is wider, and its low bits are kept when the destination is narrower.
- R4: Each side has its own predicate. A selector of 000 gives an all-ones predicate and ignores that side's mask and inversion flag. Any other selector gives, for group g, mask bit g XOR the inversion flag.
- R5: Without zeroing, a source group whose predicate bit is 0 is skipped and never moved, and a destination group whose predicate bit is 0 is skipped and left unwritten. The two indices advance independently.
- R6: With source zeroing, a source element whose predicate bit is 0 is consumed and supplies the value zero.
- R7: With destination zeroing, a destination slot whose predicate bit is 0 gets its element bytes written with zero, and no source element is consumed by that write.
- R8: SUBVL code s (0 to 3) makes every element a group of s+1 sub-elements. All sub-elements of group g share predicate bit g, and an operation covers VL×(s+1) elements.
- R9: The operation ends when either index reaches VL×(s+1). `done` is high for exactly one cycle: the cycle after the final step. That cycle carries no write. With VL=0, `done` rises in the cycle after the start is accepted.
- R10: The configuration is sampled at the edge where `start` is accepted. A `start` while an operation is running is ignored, and so is any change on the configuration inputs during the run.
- R11: Each cycle of a run does exactly one step, chosen in this priority order: end, destination slot masked (zero-write or skip), source element masked without zeroing (skip), move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| cfg_vl | input | GW | Vector length in groups, at most MAXVL (larger values are clamped) |
| cfg_subvl | input | 2 | Sub-elements per group minus one |
| src_wc | input | 2 | Source width code |
| dst_wc | input | 2 | Destination width code |
| src_psel | input | 3 | Source predicate selector (000 = all ones) |
| src_mask | input | MAXVL | Source predicate mask, one bit per group |
| src_inv | input | 1 | Invert the source mask |
| dst_psel | input | 3 | Destination predicate selector (000 = all ones) |
| dst_mask | input | MAXVL | Destination predicate mask |
| dst_inv | input | 1 | Invert the destination mask |
| src_zero | input | 1 | Masked source elements read as zero |
| dst_zero | input | 1 | Masked destination slots written with zero |
| src_base | input | AW | First source register |
| dst_base | input | AW | First destination register |
| rd_addr | output | AW | Source register read address |
| rd_data | input | 64 | Source register contents (same cycle) |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination register address |
| wr_data | output | 64 | Write data, element placed in its lane |
| wr_be | output | 8 | Byte enables of the written element |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
A masked destination slot and a masked source element can meet in the same cycle. The destination side then wins: the slot is skipped or zero-written, and the source stays where it is until a later cycle. The bench provokes this with sparse masks on both sides, under every combination of the two zeroing flags, several SUBVL values and mixed widths. It judges each run two ways. The final destination memory is compared with a bench model. The cycle in which `done` appears is compared with the step count that model predicts, so a wrong priority or an extra or missing step shows up even when the memory happens to agree.

// File: rtl/twpm_pkg.sv
package twpm_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_END,
        ACT_DSKIP,
        ACT_DZERO,
        ACT_SSKIP,
        ACT_MOVE
    } act_e;

    typedef struct packed {
        logic [1:0] swc;
        logic [1:0] dwc;
        logic       szero;
        logic       dzero;
        logic [2:0] subn;
    } mvcfg_t;

    // log2 of element size in bytes for a width code
    function automatic logic [1:0] wc_lg(input logic [1:0] wc);
        return (wc == 2'd0) ? 2'd3 : (wc - 2'd1);
    endfunction

    // byte enables of an element placed at lane 0
    function automatic logic [7:0] wc_be(input logic [1:0] wc);
        case (wc)
            2'd1:    return 8'h01;
            2'd2:    return 8'h03;
            2'd3:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] be_bits(input logic [7:0] be);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/twpm_side.sv
module twpm_side
    import twpm_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int AW    = 6,
    parameter int GW    = 4,
    parameter int FW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             skip,
    input  logic [2:0]       subn,
    input  logic [FW-1:0]    total,
    input  logic [MAXVL-1:0] emask,
    input  logic [1:0]       wc,
    input  logic [AW-1:0]    base,
    output logic             at_end,
    output logic             pbit,
    output logic [AW-1:0]    addr,
    output logic [2:0]       lane
);
    logic [FW-1:0] flat;
    logic [GW-1:0] grp;
    logic [1:0]    sub;
    logic [FW+2:0] boff;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            flat <= '0;
            grp  <= '0;
            sub  <= '0;
        end else if (skip) begin
            flat <= flat + FW'(subn);
            grp  <= grp + GW'(1);
            sub  <= '0;
        end else if (step) begin
            flat <= flat + FW'(1);
            if ({1'b0, sub} + 3'd1 == subn) begin
                sub <= '0;
                grp <= grp + GW'(1);
            end else begin
                sub <= sub + 2'd1;
            end
        end
    end

    always_comb begin
        pbit = 1'b0;
        for (int i = 0; i < MAXVL; i++)
            if (grp == GW'(i)) pbit = emask[i];
    end

    assign at_end = (flat == total);
    assign boff   = {3'b000, flat} << wc_lg(wc);
    assign addr   = base + AW'(boff >> 3);
    assign lane   = boff[2:0];

    // R8: a group is skipped only from its first sub-element
    a_r8_skip_whole_group: assert property (@(posedge clk) disable iff (rst)
        skip |-> (sub == 2'd0));

    // R9: the index never runs past the element count
    a_r9_index_bound: assert property (@(posedge clk) disable iff (rst)
        !load |-> (flat <= total));

endmodule

// File: rtl/twpm_lane.sv
module twpm_lane
    import twpm_pkg::*;
(
    input  logic [63:0] rd_data,
    input  logic [2:0]  slane,
    input  logic [1:0]  swc,
    input  logic        szval,
    input  logic [2:0]  dlane,
    input  logic [1:0]  dwc,
    input  logic        dzval,
    output logic [63:0] wr_data,
    output logic [7:0]  wr_be
);
    logic [63:0] elem;
    logic [63:0] dval;

    always_comb begin
        elem = (rd_data >> {slane, 3'b000}) & be_bits(wc_be(swc));
        if (szval) elem = '0;
        dval = elem & be_bits(wc_be(dwc));
        if (dzval) dval = '0;
        wr_data = dval << {dlane, 3'b000};
        wr_be   = wc_be(dwc) << dlane;
    end

endmodule

// File: rtl/twpred_move.sv
module twpred_move
    import twpm_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int AW    = 6,
    localparam int GW   = $clog2(MAXVL + 1),
    localparam int FW   = $clog2(4 * MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [GW-1:0]    cfg_vl,
    input  logic [1:0]       cfg_subvl,
    input  logic [1:0]       src_wc,
    input  logic [1:0]       dst_wc,
    input  logic [2:0]       src_psel,
    input  logic [MAXVL-1:0] src_mask,
    input  logic             src_inv,
    input  logic [2:0]       dst_psel,
    input  logic [MAXVL-1:0] dst_mask,
    input  logic             dst_inv,
    input  logic             src_zero,
    input  logic             dst_zero,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    output logic [AW-1:0]    rd_addr,
    input  logic [63:0]      rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [63:0]      wr_data,
    output logic [7:0]       wr_be,
    output logic             done
);
    logic             busy;
    mvcfg_t           cfg;
    logic [MAXVL-1:0] smask_q, dmask_q;
    logic [FW-1:0]    total_q;
    logic [AW-1:0]    sbase_q, dbase_q;
    logic             load;
    act_e             act;

    logic             s_end, s_p, d_end, d_p;
    logic [2:0]       s_lane, d_lane;

    logic [GW-1:0]    vl_c;
    logic [2:0]       subn_in;

    assign load    = start && !busy;
    assign vl_c    = (cfg_vl > GW'(MAXVL)) ? GW'(MAXVL) : cfg_vl;
    assign subn_in = {1'b0, cfg_subvl} + 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cfg     <= '0;
            smask_q <= '0;
            dmask_q <= '0;
            total_q <= '0;
            sbase_q <= '0;
            dbase_q <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            cfg.swc   <= src_wc;
            cfg.dwc   <= dst_wc;
            cfg.szero <= src_zero;
            cfg.dzero <= dst_zero;
            cfg.subn  <= subn_in;
            smask_q   <= (src_psel == 3'b000) ? '1 : (src_mask ^ {MAXVL{src_inv}});
            dmask_q   <= (dst_psel == 3'b000) ? '1 : (dst_mask ^ {MAXVL{dst_inv}});
            total_q   <= FW'(vl_c) * FW'(subn_in);
            sbase_q   <= src_base;
            dbase_q   <= dst_base;
        end else if (act == ACT_END) begin
            busy <= 1'b0;
        end
    end

    // one step per cycle, destination side resolved before source side
    always_comb begin
        if (!busy)                     act = ACT_IDLE;
        else if (s_end || d_end)       act = ACT_END;
        else if (!d_p)                 act = cfg.dzero ? ACT_DZERO : ACT_DSKIP;
        else if (!s_p && !cfg.szero)   act = ACT_SSKIP;
        else                           act = ACT_MOVE;
    end

    twpm_side #(.MAXVL(MAXVL), .AW(AW), .GW(GW), .FW(FW)) u_src (
        .clk(clk), .rst(rst), .load(load),
        .step(act == ACT_MOVE), .skip(act == ACT_SSKIP),
        .subn(cfg.subn), .total(total_q), .emask(smask_q),
        .wc(cfg.swc), .base(sbase_q),
        .at_end(s_end), .pbit(s_p), .addr(rd_addr), .lane(s_lane)
    );

    twpm_side #(.MAXVL(MAXVL), .AW(AW), .GW(GW), .FW(FW)) u_dst (
        .clk(clk), .rst(rst), .load(load),
        .step(act == ACT_MOVE || act == ACT_DZERO), .skip(act == ACT_DSKIP),
        .subn(cfg.subn), .total(total_q), .emask(dmask_q),
        .wc(cfg.dwc), .base(dbase_q),
        .at_end(d_end), .pbit(d_p), .addr(wr_addr), .lane(d_lane)
    );

    twpm_lane u_lane (
        .rd_data(rd_data), .slane(s_lane), .swc(cfg.swc), .szval(!s_p),
        .dlane(d_lane), .dwc(cfg.dwc), .dzval(act == ACT_DZERO),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    assign wr_en = (act == ACT_MOVE) || (act == ACT_DZERO);
    assign done  = (act == ACT_END);

    // R2: nothing outside the enabled bytes carries data
    a_r2_data_in_lanes: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_data & ~be_bits(wr_be)) == 64'd0));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: no write follows the end of an operation
    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !wr_en);

    // R10: the sampled configuration holds for the whole run
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(cfg) && $stable(total_q)));

endmodule

// File: tb/tb_twpred_move.sv
`timescale 1ns/1ps
module tb_twpred_move;
    localparam int MAXVL = 8;
    localparam int AW    = 6;
    localparam int GW    = $clog2(MAXVL + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    always #2.5 clk = ~clk;

    int c_vl, c_sv, c_swc, c_dwc, c_ps, c_pd, c_sm, c_dm;
    int c_si, c_di, c_sz, c_dz, c_sb, c_db;

    logic [AW-1:0] rd_addr, wr_addr;
    logic [63:0]   rd_data, wr_data;
    logic [7:0]    wr_be;
    logic          wr_en, done;

    logic [63:0] smem [64];
    logic [63:0] dmem [64];
    logic [63:0] emem [64];

    int checks = 0;
    int errors = 0;

    assign rd_data = smem[rd_addr];

    twpred_move #(.MAXVL(MAXVL), .AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_vl(GW'(c_vl)), .cfg_subvl(2'(c_sv)),
        .src_wc(2'(c_swc)), .dst_wc(2'(c_dwc)),
        .src_psel(3'(c_ps)), .src_mask(MAXVL'(c_sm)), .src_inv(c_si[0]),
        .dst_psel(3'(c_pd)), .dst_mask(MAXVL'(c_dm)), .dst_inv(c_di[0]),
        .src_zero(c_sz[0]), .dst_zero(c_dz[0]),
        .src_base(AW'(c_sb)), .dst_base(AW'(c_db)),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .done(done)
    );

    always @(posedge clk)
        if (wr_en)
            for (int k = 0; k < 8; k++)
                if (wr_be[k]) dmem[wr_addr][k*8 +: 8] <= wr_data[k*8 +: 8];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input int wc);
        return (wc == 0) ? 8 : (1 << (wc - 1));
    endfunction

    function automatic bit pred(input int sel, input int m, input int inv, input int g);
        if (sel == 0) return 1'b1;
        return 1'(((m >> g) & 1) ^ (inv & 1));
    endfunction

    function automatic logic [63:0] get_src(input int idx);
        int b = nbytes(c_swc);
        int off = idx * b;
        logic [63:0] v = smem[(c_sb + off / 8) % 64] >> ((off % 8) * 8);
        if (b < 8) v = v & ((64'd1 << (b * 8)) - 64'd1);
        return v;
    endfunction

    task automatic put_dst(input int idx, input logic [63:0] v);
        int b = nbytes(c_dwc);
        int off = idx * b;
        int r = (c_db + off / 8) % 64;
        for (int k = 0; k < b; k++)
            emem[r][((off % 8) + k) * 8 +: 8] = v[k*8 +: 8];
    endtask

    task automatic model(output int steps);
        int sn = c_sv + 1;
        int tot = c_vl * sn;
        int si = 0;
        int di = 0;
        bit sp, dp;
        steps = 0;
        while (si < tot && di < tot) begin
            dp = pred(c_pd, c_dm, c_di, di / sn);
            sp = pred(c_ps, c_sm, c_si, si / sn);
            if (!dp) begin
                if (c_dz != 0) begin put_dst(di, 64'd0); di++; end
                else di += sn;
            end else if (!sp && c_sz == 0) begin
                si += sn;
            end else begin
                put_dst(di, sp ? get_src(si) : 64'd0);
                si++; di++;
            end
            steps++;
        end
    endtask

    task automatic run(input string tag, input bit poke);
        int steps;
        int n = 1;
        int got = 0;
        int bad = -1;
        for (int i = 0; i < 64; i++) begin
            dmem[i] = {$urandom, $urandom};
            emem[i] = dmem[i];
        end
        model(steps);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (got == 0 && n < 400) begin
            if (done) got = n;
            if (poke && n == 2) begin
                start = 1'b1;
                c_vl = 3; c_swc = (c_swc + 1) % 4; c_dwc = (c_dwc + 2) % 4;
                c_pd = 5; c_dm = 8'h0F; c_dz = 1; c_sb = 40;
            end
            if (poke && n == 3) start = 1'b0;
            if (got == 0) begin @(negedge clk); n++; end
        end
        start = 1'b0;
        chk(got == steps + 1, {tag, " R9 R11 done cycle"}, got, steps + 1);
        @(negedge clk);
        chk(!wr_en && !done, {tag, " R9 quiet after done"}, {wr_en, done}, 0);
        for (int i = 0; i < 64; i++)
            if (bad < 0 && dmem[i] !== emem[i]) bad = i;
        chk(bad < 0, {tag, " destination memory"}, (bad < 0) ? 0 : dmem[bad],
            (bad < 0) ? 0 : emem[bad]);
    endtask

    task automatic setc(input int vl, sv, swc, dwc, ps, sm, si, pd, dm, di, sz, dz);
        c_vl = vl; c_sv = sv; c_swc = swc; c_dwc = dwc;
        c_ps = ps; c_sm = sm; c_si = si; c_pd = pd; c_dm = dm; c_di = di;
        c_sz = sz; c_dz = dz; c_sb = 2; c_db = 20;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 64; i++) begin
            smem[i] = {$urandom, $urandom};
            dmem[i] = '0;
        end
        setc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !done, "R9 reset state", {wr_en, done}, 0);

        setc(8, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); run("R1 R3 unpack bytes", 0);
        setc(8, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); run("R2 R3 pack truncate", 0);
        setc(4, 1, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0); run("R3 32to16 subvl2", 0);
        setc(8, 0, 2, 2, 1, 8'hB2, 0, 0, 0, 0, 0, 0); run("R5 compress", 0);
        setc(8, 0, 2, 3, 0, 0, 0, 2, 8'h5A, 0, 0, 0); run("R5 expand", 0);
        setc(8, 0, 1, 2, 4, 8'h69, 0, 0, 0, 0, 1, 0); run("R6 source zeroing", 0);
        setc(8, 0, 3, 1, 0, 0, 0, 6, 8'hC3, 0, 0, 1); run("R7 dest zeroing", 0);
        setc(5, 2, 2, 0, 3, 8'h15, 0, 7, 8'h1B, 0, 0, 0); run("R8 subvl3 groups", 0);
        setc(6, 3, 1, 1, 1, 8'h2D, 1, 3, 8'h36, 0, 1, 1); run("R8 R11 both masked", 0);
        setc(8, 0, 0, 0, 0, 8'h00, 1, 1, 8'h0F, 1, 0, 0); run("R4 sel000 and inverted", 0);
        setc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); run("R9 vl zero", 0);
        setc(8, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); run("R10 restart ignored", 1);

        for (int t = 0; t < 40; t++) begin
            setc($urandom % 9, $urandom % 4, $urandom % 4, $urandom % 4,
                 $urandom % 8, $urandom % 256, $urandom % 2,
                 $urandom % 8, $urandom % 256, $urandom % 2,
                 $urandom % 2, $urandom % 2);
            c_sb = $urandom % 64;
            c_db = $urandom % 64;
            run("R5 R6 R7 random", 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule